// File: doc/BRIEF.md
# Privileged Trap and Return Controller

This block keeps the machine-level and supervisor-level trap state of a 32-bit RISC-V hart. It also decides which of the two levels handles each trap. The pipeline gives it three kinds of request. The first is a trap (an interrupt flag, a cause code, an optional trap value and the PC of the faulting instruction). The second is a system instruction word, which the block decodes into MRET, SRET or ECALL. The third is a CSR access. For each request the block updates the privileged registers in a single clock edge. On the next cycle it gives the pipeline a redirect target or an illegal-instruction pulse, along with the current privilege level.

Each trap cause is looked up in one of two delegation masks: the interrupt mask for interrupts and the exception mask for exceptions. A set bit sends the trap to supervisor mode; a clear bit sends it to machine mode. Entering either level saves the interrupt-enable bit and the prior privilege into the shared status word. The matching return instruction restores them. A return that is not allowed at the current level raises the illegal flag and leaves all state as it was. Trap vectors work in direct mode only.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the privilege level is 3, `redirect_pc` is 0x80000000, `redirect_valid` and `illegal` are low, mstatus (0x300) reads 0x00001800 (previous-machine-privilege field = 3), and both delegation masks (0x302 exceptions, 0x303 interrupts) read 0.
- R2: CSRs at 0x300, 0x302, 0x303, 0x305, 0x340, 0x341, 0x342, 0x343, 0x100, 0x105, 0x140, 0x141, 0x142 and 0x143 are read combinationally on `csr_rdata` while `csr_en` is high. A write takes effect at the next edge. The two trap-vector registers (0x305, 0x105) keep bits 31:2 and read bits 1:0 as zero.
- R3: A trap goes to supervisor (level 1) when bit `cause` is set in the interrupt mask (for interrupts) or the exception mask (for exceptions); otherwise it goes to machine (level 3).
- R4: A machine-level trap updates the following, all at one edge. mcause becomes {irq flag in bit 31, code in bits 30:0}. mepc becomes `req_pc`. mtval becomes `trap_val`, but only when `trap_has_val` is high. The status bit 7 takes the old bit 3, bit 3 is cleared, and bits 12:11 take the prior privilege. The next cycle shows `redirect_valid` with `redirect_pc` equal to the mtvec base.
- R5: A supervisor-level trap updates scause, sepc and stval in the same way. The status bit 5 takes the old bit 1, bit 1 is cleared, and bit 8 takes bit 0 of the prior privilege. The redirect goes to the stvec base.
- R6: MRET (0x30200073) at level 3 has these effects. Bit 3 takes bit 7, and bit 7 is set. The privilege becomes the old bits 12:11, and bits 12:11 are cleared. The redirect goes to mepc.
- R7: MRET below level 3 pulses `illegal` for one cycle. It gives no redirect and changes no state.
- R8: SRET (0x10200073) at level 1 or above has these effects. Bit 1 takes bit 5, and bit 5 is set. The privilege becomes the old bit 8, and bit 8 is cleared. The redirect goes to sepc. At level 0, SRET pulses `illegal` and changes nothing.
- R9: ECALL (0x00000073) raises exception cause 11 at `req_pc` and leaves the trap-value register unchanged. Any other `sys_insn` value has no effect.
- R10: sstatus (0x100) reads only bits 1, 5 and 8 of the status word, with all other bits zero. A write to it changes only those three bits.
- R11: An access to an address that is not implemented pulses `illegal` and has no effect. Addresses 0x104, 0x106, 0x144 and 0x180 read as zero, ignore writes and are not illegal.
- R12: `redirect_valid` and `illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_cause | input | CAUSE_W | Trap cause code |
| trap_has_val | input | 1 | `trap_val` is to be recorded |
| trap_val | input | 32 | Trap value |
| req_pc | input | 32 | PC of the trapping or system instruction |
| sys_valid | input | 1 | System instruction present |
| sys_insn | input | 32 | System instruction word |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| priv_lvl | output | 2 | Current privilege level |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The assertions rely on the pipeline sending at most one of `trap_valid`, `sys_valid` and `csr_en` in any cycle, and one of them checks that this holds. The stimulus drives each request for exactly one cycle from a task and drops it before the next request starts, so requests never overlap. The routing and illegal-return properties also assume that `trap_cause` stays within the mask width. The bench uses only cause codes below 32.

// File: rtl/privtrap_pkg.sv
package privtrap_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned TVEC_LSB   = 2;
    localparam int unsigned ECALL_CODE = 11;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_M = 2'd3;

    // status word field positions
    localparam int unsigned ST_SIE  = 1;
    localparam int unsigned ST_MIE  = 3;
    localparam int unsigned ST_SPIE = 5;
    localparam int unsigned ST_MPIE = 7;
    localparam int unsigned ST_SPP  = 8;
    localparam int unsigned ST_MPPL = 11;
    localparam int unsigned ST_MPPH = 12;

    // instruction words
    localparam logic [31:0] OP_MRET  = 32'h3020_0073;
    localparam logic [31:0] OP_SRET  = 32'h1020_0073;
    localparam logic [31:0] OP_ECALL = 32'h0000_0073;

    // CSR addresses
    localparam logic [11:0] A_MSTATUS  = 12'h300;
    localparam logic [11:0] A_MEDELEG  = 12'h302;
    localparam logic [11:0] A_MIDELEG  = 12'h303;
    localparam logic [11:0] A_MTVEC    = 12'h305;
    localparam logic [11:0] A_MSCRATCH = 12'h340;
    localparam logic [11:0] A_MEPC     = 12'h341;
    localparam logic [11:0] A_MCAUSE   = 12'h342;
    localparam logic [11:0] A_MTVAL    = 12'h343;
    localparam logic [11:0] A_SSTATUS  = 12'h100;
    localparam logic [11:0] A_SIE      = 12'h104;
    localparam logic [11:0] A_STVEC    = 12'h105;
    localparam logic [11:0] A_SCNTEN   = 12'h106;
    localparam logic [11:0] A_SSCRATCH = 12'h140;
    localparam logic [11:0] A_SEPC     = 12'h141;
    localparam logic [11:0] A_SCAUSE   = 12'h142;
    localparam logic [11:0] A_STVAL    = 12'h143;
    localparam logic [11:0] A_SIP      = 12'h144;
    localparam logic [11:0] A_SATP     = 12'h180;

    typedef struct packed {
        logic                       sie;
        logic                       mie;
        logic                       spie;
        logic                       mpie;
        logic                       spp;
        logic [1:0]                 mpp;
        logic [XLEN-1:TVEC_LSB]     mtvec_base;
        logic [XLEN-1:TVEC_LSB]     stvec_base;
        logic [XLEN-1:0]            mepc;
        logic [XLEN-1:0]            sepc;
        logic [XLEN-1:0]            mcause;
        logic [XLEN-1:0]            scause;
        logic [XLEN-1:0]            mtval;
        logic [XLEN-1:0]            stval;
        logic [XLEN-1:0]            mscratch;
        logic [XLEN-1:0]            sscratch;
        logic [XLEN-1:0]            medeleg;
        logic [XLEN-1:0]            mideleg;
    } arch_t;

    typedef struct packed {
        logic [1:0]      priv;
        arch_t           arch;
        logic            redir_v;
        logic [XLEN-1:0] redir_pc;
        logic            illegal;
    } ctl_t;

    typedef enum logic [4:0] {
        CS_MSTATUS, CS_SSTATUS, CS_MEDELEG, CS_MIDELEG,
        CS_MTVEC, CS_STVEC, CS_MSCRATCH, CS_SSCRATCH,
        CS_MEPC, CS_SEPC, CS_MCAUSE, CS_SCAUSE,
        CS_MTVAL, CS_STVAL, CS_ZERO, CS_NONE
    } csr_sel_e;

    typedef enum logic [1:0] {
        SYS_NONE, SYS_MRET, SYS_SRET, SYS_ECALL
    } sys_op_e;

    function automatic logic [XLEN-1:0] pack_status(input arch_t a);
        logic [XLEN-1:0] r;
        r                  = '0;
        r[ST_SIE]          = a.sie;
        r[ST_MIE]          = a.mie;
        r[ST_SPIE]         = a.spie;
        r[ST_MPIE]         = a.mpie;
        r[ST_SPP]          = a.spp;
        r[ST_MPPH:ST_MPPL] = a.mpp;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] sview_mask();
        logic [XLEN-1:0] m;
        m          = '0;
        m[ST_SIE]  = 1'b1;
        m[ST_SPIE] = 1'b1;
        m[ST_SPP]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sys_decode.sv
module sys_decode
    import privtrap_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output sys_op_e         op
);
    always_comb begin
        unique case (insn)
            OP_MRET:  op = SYS_MRET;
            OP_SRET:  op = SYS_SRET;
            OP_ECALL: op = SYS_ECALL;
            default:  op = SYS_NONE;
        endcase
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import privtrap_pkg::*;
#(
    parameter int unsigned CAUSE_W = 5
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    exc_mask,
    input  logic [XLEN-1:0]    irq_mask,
    output logic               to_super
);
    logic [XLEN-1:0] sel_mask;

    always_comb begin
        sel_mask = is_irq ? irq_mask : exc_mask;
        to_super = sel_mask[cause];
    end
endmodule

// File: rtl/csr_map.sv
module csr_map
    import privtrap_pkg::*;
(
    input  logic [11:0]     addr,
    input  arch_t           arch,
    output csr_sel_e        sel,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] status_w;

    always_comb begin
        status_w = pack_status(arch);
        unique case (addr)
            A_MSTATUS:  sel = CS_MSTATUS;
            A_SSTATUS:  sel = CS_SSTATUS;
            A_MEDELEG:  sel = CS_MEDELEG;
            A_MIDELEG:  sel = CS_MIDELEG;
            A_MTVEC:    sel = CS_MTVEC;
            A_STVEC:    sel = CS_STVEC;
            A_MSCRATCH: sel = CS_MSCRATCH;
            A_SSCRATCH: sel = CS_SSCRATCH;
            A_MEPC:     sel = CS_MEPC;
            A_SEPC:     sel = CS_SEPC;
            A_MCAUSE:   sel = CS_MCAUSE;
            A_SCAUSE:   sel = CS_SCAUSE;
            A_MTVAL:    sel = CS_MTVAL;
            A_STVAL:    sel = CS_STVAL;
            A_SIE, A_SCNTEN, A_SIP, A_SATP: sel = CS_ZERO;
            default:    sel = CS_NONE;
        endcase

        unique case (sel)
            CS_MSTATUS:  rdata = status_w;
            CS_SSTATUS:  rdata = status_w & sview_mask();
            CS_MEDELEG:  rdata = arch.medeleg;
            CS_MIDELEG:  rdata = arch.mideleg;
            CS_MTVEC:    rdata = {arch.mtvec_base, {TVEC_LSB{1'b0}}};
            CS_STVEC:    rdata = {arch.stvec_base, {TVEC_LSB{1'b0}}};
            CS_MSCRATCH: rdata = arch.mscratch;
            CS_SSCRATCH: rdata = arch.sscratch;
            CS_MEPC:     rdata = arch.mepc;
            CS_SEPC:     rdata = arch.sepc;
            CS_MCAUSE:   rdata = arch.mcause;
            CS_SCAUSE:   rdata = arch.scause;
            CS_MTVAL:    rdata = arch.mtval;
            CS_STVAL:    rdata = arch.stval;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
    import privtrap_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h8000_0000,
    parameter int unsigned CAUSE_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               trap_has_val,
    input  logic [31:0]        trap_val,
    input  logic [31:0]        req_pc,
    input  logic               sys_valid,
    input  logic [31:0]        sys_insn,
    input  logic               csr_en,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    output logic               redirect_valid,
    output logic [31:0]        redirect_pc,
    output logic [1:0]         priv_lvl,
    output logic               illegal
);
    localparam int unsigned CODE_PAD = XLEN - 1 - CAUSE_W;

    ctl_t               q, d;
    sys_op_e            sys_op;
    csr_sel_e           csr_sel;
    logic               t_fire;
    logic               t_irq;
    logic               t_hasval;
    logic [CAUSE_W-1:0] t_cause;
    logic               to_super;
    logic [XLEN-1:0]    t_code;

    sys_decode u_dec (
        .insn (sys_insn),
        .op   (sys_op)
    );

    always_comb begin
        t_fire   = trap_valid | (sys_valid & (sys_op == SYS_ECALL));
        t_irq    = trap_valid & trap_is_irq;
        t_hasval = trap_valid & trap_has_val;
        t_cause  = trap_valid ? trap_cause : CAUSE_W'(ECALL_CODE);
        t_code   = {t_irq, {CODE_PAD{1'b0}}, t_cause};
    end

    trap_route #(.CAUSE_W(CAUSE_W)) u_route (
        .is_irq   (t_irq),
        .cause    (t_cause),
        .exc_mask (q.arch.medeleg),
        .irq_mask (q.arch.mideleg),
        .to_super (to_super)
    );

    csr_map u_map (
        .addr  (csr_addr),
        .arch  (q.arch),
        .sel   (csr_sel),
        .rdata (csr_rdata)
    );

    always_comb begin
        d         = q;
        d.redir_v = 1'b0;
        d.illegal = 1'b0;

        if (t_fire) begin
            d.redir_v = 1'b1;
            if (to_super) begin
                d.arch.scause = t_code;
                if (t_hasval) d.arch.stval = trap_val;
                d.arch.sepc   = req_pc;
                d.arch.spie   = q.arch.sie;
                d.arch.sie    = 1'b0;
                d.arch.spp    = q.priv[0];
                d.priv        = LVL_S;
                d.redir_pc    = {q.arch.stvec_base, {TVEC_LSB{1'b0}}};
            end else begin
                d.arch.mcause = t_code;
                if (t_hasval) d.arch.mtval = trap_val;
                d.arch.mepc   = req_pc;
                d.arch.mpie   = q.arch.mie;
                d.arch.mie    = 1'b0;
                d.arch.mpp    = q.priv;
                d.priv        = LVL_M;
                d.redir_pc    = {q.arch.mtvec_base, {TVEC_LSB{1'b0}}};
            end
        end else if (sys_valid && sys_op == SYS_MRET) begin
            if (q.priv != LVL_M) begin
                d.illegal = 1'b1;
            end else begin
                d.arch.mie  = q.arch.mpie;
                d.arch.mpie = 1'b1;
                d.priv      = q.arch.mpp;
                d.arch.mpp  = LVL_U;
                d.redir_v   = 1'b1;
                d.redir_pc  = q.arch.mepc;
            end
        end else if (sys_valid && sys_op == SYS_SRET) begin
            if (q.priv < LVL_S) begin
                d.illegal = 1'b1;
            end else begin
                d.arch.sie  = q.arch.spie;
                d.arch.spie = 1'b1;
                d.priv      = {1'b0, q.arch.spp};
                d.arch.spp  = 1'b0;
                d.redir_v   = 1'b1;
                d.redir_pc  = q.arch.sepc;
            end
        end else if (csr_en) begin
            if (csr_sel == CS_NONE) begin
                d.illegal = 1'b1;
            end else if (csr_we) begin
                unique case (csr_sel)
                    CS_MSTATUS: begin
                        d.arch.sie  = csr_wdata[ST_SIE];
                        d.arch.mie  = csr_wdata[ST_MIE];
                        d.arch.spie = csr_wdata[ST_SPIE];
                        d.arch.mpie = csr_wdata[ST_MPIE];
                        d.arch.spp  = csr_wdata[ST_SPP];
                        d.arch.mpp  = csr_wdata[ST_MPPH:ST_MPPL];
                    end
                    CS_SSTATUS: begin
                        d.arch.sie  = csr_wdata[ST_SIE];
                        d.arch.spie = csr_wdata[ST_SPIE];
                        d.arch.spp  = csr_wdata[ST_SPP];
                    end
                    CS_MEDELEG:  d.arch.medeleg    = csr_wdata;
                    CS_MIDELEG:  d.arch.mideleg    = csr_wdata;
                    CS_MTVEC:    d.arch.mtvec_base = csr_wdata[XLEN-1:TVEC_LSB];
                    CS_STVEC:    d.arch.stvec_base = csr_wdata[XLEN-1:TVEC_LSB];
                    CS_MSCRATCH: d.arch.mscratch   = csr_wdata;
                    CS_SSCRATCH: d.arch.sscratch   = csr_wdata;
                    CS_MEPC:     d.arch.mepc       = csr_wdata;
                    CS_SEPC:     d.arch.sepc       = csr_wdata;
                    CS_MCAUSE:   d.arch.mcause     = csr_wdata;
                    CS_SCAUSE:   d.arch.scause     = csr_wdata;
                    CS_MTVAL:    d.arch.mtval      = csr_wdata;
                    CS_STVAL:    d.arch.stval      = csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.priv     <= LVL_M;
            q.arch.mpp <= LVL_M;
            q.redir_pc <= RESET_PC;
        end else begin
            q <= d;
        end
    end

    assign redirect_valid = q.redir_v;
    assign redirect_pc    = q.redir_pc;
    assign priv_lvl       = q.priv;
    assign illegal        = q.illegal;

    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid && !illegal); // R4
    AST_DELEG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && to_super |=> priv_lvl == LVL_S && !q.arch.sie); // R3
    AST_MACHINE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !to_super |=> priv_lvl == LVL_M && !q.arch.mie); // R4
    AST_MRET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sys_valid && sys_op == SYS_MRET && priv_lvl != LVL_M
        |=> illegal && !redirect_valid && $stable(priv_lvl)); // R7
    AST_SRET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sys_valid && sys_op == SYS_SRET && priv_lvl == LVL_U
        |=> illegal && $stable(priv_lvl) && $stable(q.arch.sie)); // R8
    AST_SSTATUS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en && csr_we && csr_addr == A_SSTATUS
        |=> $stable(q.arch.mie) && $stable(q.arch.mpie) && $stable(q.arch.mpp)); // R10
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({trap_valid, sys_valid, csr_en}) <= 1); // R12
    AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && illegal)); // R12

endmodule

// File: tb/sim_priv_trap_unit.sv
module sim_priv_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_valid, trap_is_irq, trap_has_val;
    logic [4:0]  trap_cause;
    logic [31:0] trap_val, req_pc;
    logic        sys_valid;
    logic [31:0] sys_insn;
    logic        csr_en, csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata, csr_rdata;
    logic        redirect_valid, illegal;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    priv_trap_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .trap_has_val(trap_has_val),
        .trap_val(trap_val), .req_pc(req_pc),
        .sys_valid(sys_valid), .sys_insn(sys_insn),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .priv_lvl(priv_lvl), .illegal(illegal)
    );

    // {addr, write data, expected readback, requirement number}
    localparam int NV = 16;
    localparam logic [83:0] TBL [0:NV-1] = '{
        {12'h305, 32'h0000_1003, 32'h0000_1000, 8'd2},  // R2 low bits dropped
        {12'h105, 32'h0000_2002, 32'h0000_2000, 8'd2},  // R2
        {12'h340, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'd2},
        {12'h140, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 8'd2},
        {12'h341, 32'h0000_0400, 32'h0000_0400, 8'd2},
        {12'h141, 32'h0000_0500, 32'h0000_0500, 8'd2},
        {12'h343, 32'h1111_1111, 32'h1111_1111, 8'd2},
        {12'h143, 32'h2222_2222, 32'h2222_2222, 8'd2},
        {12'h342, 32'h8000_000B, 32'h8000_000B, 8'd2},
        {12'h142, 32'h0000_0003, 32'h0000_0003, 8'd2},
        {12'h302, 32'h0000_0800, 32'h0000_0800, 8'd2},  // ECALL delegated
        {12'h303, 32'h0000_0020, 32'h0000_0020, 8'd2},  // irq 5 delegated
        {12'h300, 32'hFFFF_FFFF, 32'h0000_19AA, 8'd4},  // R4 field set only
        {12'h300, 32'h0000_1800, 32'h0000_1800, 8'd4},
        {12'h104, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11}, // R11 reads zero
        {12'h180, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        trap_valid = 0; trap_is_irq = 0; trap_has_val = 0; trap_cause = '0;
        trap_val = '0; sys_valid = 0; sys_insn = '0;
        csr_en = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] w, output logic ill);
        @(negedge clk);
        csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = w;
        @(negedge clk);
        idle();
        ill = illegal;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] v, output logic ill);
        @(negedge clk);
        csr_en = 1; csr_we = 0; csr_addr = a;
        #1 v = csr_rdata;
        @(negedge clk);
        idle();
        ill = illegal;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        logic        il;
        csr_rd(a, v, il);
        chk(tag, v, exp);
    endtask

    task automatic do_trap(input logic irq, input logic [4:0] c, input logic hv,
                           input logic [31:0] v, input logic [31:0] pc);
        @(negedge clk);
        trap_valid = 1; trap_is_irq = irq; trap_cause = c;
        trap_has_val = hv; trap_val = v; req_pc = pc;
        @(negedge clk);
        idle();
    endtask

    task automatic do_sys(input logic [31:0] insn, input logic [31:0] pc);
        @(negedge clk);
        sys_valid = 1; sys_insn = insn; req_pc = pc;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        il;
        idle();
        req_pc = '0;
        rst_n  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 priv", {30'd0, priv_lvl}, 32'd3);
        chk("R1 redirect_pc", redirect_pc, 32'h8000_0000);
        chk("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
        rd_chk("R1 mstatus", 12'h300, 32'h0000_1800);
        rd_chk("R1 medeleg", 12'h302, 32'h0);
        rd_chk("R1 mideleg", 12'h303, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            csr_wr(TBL[i][83:72], TBL[i][71:40], il);
            chk($sformatf("R%0d write illegal @%03h", TBL[i][7:0], TBL[i][83:72]), {31'd0, il}, 32'd0);
            csr_rd(TBL[i][83:72], v, il);
            chk($sformatf("R%0d readback @%03h", TBL[i][7:0], TBL[i][83:72]), v, TBL[i][39:8]);
        end

        // R10 sstatus view
        csr_wr(12'h100, 32'hFFFF_FFFF, il);
        rd_chk("R10 sstatus read", 12'h100, 32'h0000_0122);
        rd_chk("R10 mstatus after sstatus write", 12'h300, 32'h0000_1922);
        csr_wr(12'h100, 32'h0, il);
        rd_chk("R10 sstatus clear", 12'h300, 32'h0000_1800);
        csr_wr(12'h300, 32'h0000_1808, il);

        // R4 machine trap with value
        do_trap(0, 5'd2, 1, 32'h0000_DEAD, 32'h8000_0100);
        chk("R4 redirect_valid", {31'd0, redirect_valid}, 32'd1);
        chk("R4 redirect_pc", redirect_pc, 32'h0000_1000);
        chk("R3 priv machine", {30'd0, priv_lvl}, 32'd3);
        rd_chk("R4 mepc", 12'h341, 32'h8000_0100);
        rd_chk("R4 mcause", 12'h342, 32'h0000_0002);
        rd_chk("R4 mtval", 12'h343, 32'h0000_DEAD);
        rd_chk("R4 mstatus", 12'h300, 32'h0000_1880);

        // R4 interrupt without value, not delegated
        do_trap(1, 5'd7, 0, 32'hFFFF_FFFF, 32'h8000_0200);
        chk("R3 irq7 stays machine", {30'd0, priv_lvl}, 32'd3);
        rd_chk("R4 mcause irq", 12'h342, 32'h8000_0007);
        rd_chk("R4 mtval kept", 12'h343, 32'h0000_DEAD);
        rd_chk("R4 mstatus 2", 12'h300, 32'h0000_1800);

        // R6 MRET to user
        csr_wr(12'h300, 32'h0000_0080, il);
        do_sys(32'h3020_0073, 32'h0);
        chk("R6 redirect_pc", redirect_pc, 32'h8000_0200);
        chk("R6 redirect_valid", {31'd0, redirect_valid}, 32'd1);
        chk("R6 priv", {30'd0, priv_lvl}, 32'd0);
        rd_chk("R6 mstatus", 12'h300, 32'h0000_0088);

        // R7 / R8 illegal returns in user
        do_sys(32'h3020_0073, 32'h0);
        chk("R7 illegal", {31'd0, illegal}, 32'd1);
        chk("R7 no redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R7 priv kept", {30'd0, priv_lvl}, 32'd0);
        do_sys(32'h1020_0073, 32'h0);
        chk("R8 illegal in user", {31'd0, illegal}, 32'd1);
        rd_chk("R8 status kept", 12'h300, 32'h0000_0088);

        // R9 unknown system word
        do_sys(32'h0010_0073, 32'h0);
        chk("R9 other word illegal", {31'd0, illegal}, 32'd0);
        chk("R9 other word redirect", {31'd0, redirect_valid}, 32'd0);

        // R9 ECALL delegated to supervisor
        do_sys(32'h0000_0073, 32'h0000_3000);
        chk("R9 ecall redirect", redirect_pc, 32'h0000_2000);
        chk("R3 ecall priv", {30'd0, priv_lvl}, 32'd1);
        rd_chk("R9 sepc", 12'h141, 32'h0000_3000);
        rd_chk("R9 scause", 12'h142, 32'h0000_000B);
        rd_chk("R9 stval kept", 12'h143, 32'h2222_2222);

        // R5 supervisor interrupt from supervisor
        csr_wr(12'h100, 32'h0000_0002, il);
        rd_chk("R10 sie set", 12'h300, 32'h0000_008A);
        do_trap(1, 5'd5, 1, 32'h0000_0077, 32'h0000_4000);
        chk("R5 redirect", redirect_pc, 32'h0000_2000);
        chk("R5 priv", {30'd0, priv_lvl}, 32'd1);
        rd_chk("R5 sepc", 12'h141, 32'h0000_4000);
        rd_chk("R5 scause", 12'h142, 32'h8000_0005);
        rd_chk("R5 stval", 12'h143, 32'h0000_0077);
        rd_chk("R5 sstatus", 12'h100, 32'h0000_0120);

        // R7 MRET in supervisor
        do_sys(32'h3020_0073, 32'h0);
        chk("R7 mret in S", {31'd0, illegal}, 32'd1);
        chk("R7 priv S kept", {30'd0, priv_lvl}, 32'd1);

        // R8 SRET
        do_sys(32'h1020_0073, 32'h0);
        chk("R8 redirect", redirect_pc, 32'h0000_4000);
        chk("R8 redirect_valid", {31'd0, redirect_valid}, 32'd1);
        chk("R8 priv", {30'd0, priv_lvl}, 32'd1);
        rd_chk("R8 sstatus", 12'h100, 32'h0000_0022);

        // R4 trap from supervisor to machine
        do_trap(0, 5'd2, 0, 32'h0, 32'h0000_5000);
        chk("R3 S to M priv", {30'd0, priv_lvl}, 32'd3);
        chk("R4 S to M redirect", redirect_pc, 32'h0000_1000);
        rd_chk("R4 mstatus from S", 12'h300, 32'h0000_08A2);
        rd_chk("R4 mepc from S", 12'h341, 32'h0000_5000);

        // R11 unimplemented address
        csr_wr(12'h7C0, 32'h1234_5678, il);
        chk("R11 write illegal", {31'd0, il}, 32'd1);
        csr_rd(12'h7C0, v, il);
        chk("R11 read illegal", {31'd0, il}, 32'd1);
        rd_chk("R11 no side effect", 12'h340, 32'hA5A5_A5A5);
        csr_wr(12'h106, 32'hFFFF_FFFF, il);
        chk("R11 reserved not illegal", {31'd0, il}, 32'd0);

        // R1 reset after activity
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 priv after reset", {30'd0, priv_lvl}, 32'd3);
        chk("R1 pc after reset", redirect_pc, 32'h8000_0000);
        rd_chk("R1 mstatus after reset", 12'h300, 32'h0000_1800);
        rd_chk("R1 medeleg after reset", 12'h302, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule